// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Code Registers

This block is the digital front end of a two-channel, 16-bit parallel-input converter. Each channel has a staging register, which collects a word from the shared data bus, and an output register, which holds the code driven into that channel's converter core. A 2-bit address picks channel A, channel B, both channels or neither. The write strobe is active low and the load strobe is active high. Together they choose one of four actions: capture into staging, copy staging to output, pass the bus straight through both registers, or hold.

An active-low clear input forces all four registers to a preset. A preset-select pin chooses that preset: zero-scale (all zeros) or midscale (only the top bit set). The same preset is loaded automatically once the system reset is released.

The three control strobes arrive asynchronously. Each one passes through a two-flop synchroniser in the system clock domain. The action is decoded from the synchronised levels, and the bus and address are sampled in the cycle in which the registers update. A registered pulse marks every cycle in which an output code has just changed, so a downstream model can compare the codes.

Top module: `dual_dac_regs`

## Requirements
- R1: Address 2'b00 selects channel A only, 2'b11 selects channel B only, 2'b10 selects both channels, and 2'b01 selects neither. An unselected channel keeps both of its registers.
- R2: With clear high, write low and load low, the staging registers of the selected channels take the data bus, and no output code moves.
- R3: With clear high, write high and load high, the output registers of the selected channels take the contents of their staging registers.
- R4: With clear high, write low and load high, the staging and output registers of the selected channels both take the data bus, so the bus value appears on the output code.
- R5: With clear high, write high and load low, no register changes, whatever the bus and address do.
- R6: With clear low, all staging and output registers of both channels take the preset, whatever the write strobe, load strobe and address are.
- R7: The preset is 16'h0000 when preset-select is 0 and 16'h8000 (bit 15 set, all other bits clear) when preset-select is 1.
- R8: While the system reset is low, both codes read 16'h0000 and the update pulse is low. After the system reset is released, both codes equal the preset within three clock cycles, without any clear pulse.
- R9: When write and load are moved together as one pulse (both low, then both high), the bus word is staged while the pulse is low. It reaches the output registers of the selected channels when the pulse returns high.
- R10: A change on a strobe input becomes visible on the output codes after the third rising clock edge (two synchroniser stages plus the register), and is not visible after the second.
- R11: The update pulse is high for exactly the cycles in which either output code differs from its value in the previous cycle. One action that changes codes yields exactly one pulse cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| data_i | input | 16 | Parallel data bus |
| addr_i | input | 2 | Channel address |
| wr_n_i | input | 1 | Write strobe, active low, asynchronous |
| load_i | input | 1 | Load strobe, active high, asynchronous |
| clr_n_i | input | 1 | Clear to preset, active low, asynchronous |
| mid_sel_i | input | 1 | Preset select: 0 zero-scale, 1 midscale |
| code_a_o | output | 16 | Output code, channel A |
| code_b_o | output | 16 | Output code, channel B |
| upd_o | output | 1 | One-cycle pulse after any output code change |

## Verification
Each of the four strobe actions is applied at each of the four address codes, with data words that change every time. Each action is followed by a settle and a return to the hold state. This sweep separates the address decode from the action decode: the "neither" code and the hold action must both leave every code untouched. A transfer that follows a capture at a different address shows which staging registers were actually written.

Further sequences cover other cases:
- A tied strobe pulse confirms the staging-then-transfer order.
- Clear is asserted while the strobes request pass-through, which shows that clear wins.
- The clear preset and the power-on preset are run with both preset-select values.
- Sampling two and three cycles after a strobe change pins down the pipeline latency.

// File: rtl/dac_regs_pkg.sv
package dac_regs_pkg;

  localparam int NCH = 2;

  localparam logic [1:0] ADR_A    = 2'b00;
  localparam logic [1:0] ADR_NONE = 2'b01;
  localparam logic [1:0] ADR_BOTH = 2'b10;
  localparam logic [1:0] ADR_B    = 2'b11;

  typedef enum logic [2:0] {
    OP_HOLD,
    OP_CAPTURE,
    OP_XFER,
    OP_THRU,
    OP_CLEAR
  } op_e;

  // Clear dominates; otherwise the strobe levels pick the action.
  function automatic op_e decode_op(input logic clr_n, input logic wr_n, input logic load);
    op_e r;
    if (!clr_n)               r = OP_CLEAR;
    else if (!wr_n && !load)  r = OP_CAPTURE;
    else if (!wr_n &&  load)  r = OP_THRU;
    else if ( wr_n &&  load)  r = OP_XFER;
    else                      r = OP_HOLD;
    return r;
  endfunction

endpackage

// File: rtl/dac_strobe_sync.sv
module dac_strobe_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_nxt;

  always_comb begin
    stg_nxt = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q <= stg_nxt;
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/dac_addr_decode.sv
module dac_addr_decode
  import dac_regs_pkg::*;
(
  input  logic [1:0]     addr,
  output logic [NCH-1:0] sel
);

  always_comb begin
    unique case (addr)
      ADR_A:    sel = 2'b01;
      ADR_B:    sel = 2'b10;
      ADR_BOTH: sel = 2'b11;
      ADR_NONE: sel = 2'b00;
      default:  sel = 2'b00;
    endcase
  end

endmodule

// File: rtl/dac_chan_regs.sv
module dac_chan_regs
  import dac_regs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  op_e           op,
  input  logic          sel,
  input  logic          mid_sel,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] code,
  output logic          chg
);

  localparam logic [DW-1:0] PRESET_ZERO = '0;
  localparam logic [DW-1:0] PRESET_MID  = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0] stage_q, stage_nxt;
  logic [DW-1:0] out_q,   out_nxt;
  logic          stage_en, out_en;
  logic [DW-1:0] preset;

  assign preset = mid_sel ? PRESET_MID : PRESET_ZERO;

  always_comb begin
    stage_nxt = stage_q;
    out_nxt   = out_q;
    stage_en  = 1'b0;
    out_en    = 1'b0;
    unique case (op)
      OP_CLEAR: begin
        stage_nxt = preset;
        out_nxt   = preset;
        stage_en  = 1'b1;
        out_en    = 1'b1;
      end
      OP_CAPTURE: begin
        stage_nxt = data;
        stage_en  = sel;
      end
      OP_XFER: begin
        out_nxt = stage_q;
        out_en  = sel;
      end
      OP_THRU: begin
        stage_nxt = data;
        out_nxt   = data;
        stage_en  = sel;
        out_en    = sel;
      end
      default: begin
        stage_en = 1'b0;
        out_en   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      out_q   <= '0;
    end else begin
      if (stage_en) stage_q <= stage_nxt;
      if (out_en)   out_q   <= out_nxt;
    end
  end

  assign code = out_q;
  assign chg  = out_en && (out_nxt != out_q);

endmodule

// File: rtl/dual_dac_regs.sv
module dual_dac_regs
  import dac_regs_pkg::*;
#(
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] data_i,
  input  logic [1:0]    addr_i,
  input  logic          wr_n_i,
  input  logic          load_i,
  input  logic          clr_n_i,
  input  logic          mid_sel_i,
  output logic [DW-1:0] code_a_o,
  output logic [DW-1:0] code_b_o,
  output logic          upd_o
);

  // Strobe vector bit positions: [2] clear_n, [1] load, [0] write_n.
  localparam int          SW       = 3;
  localparam logic [SW-1:0] STRB_RST = 3'b001; // clear active, load low, write high

  logic [SW-1:0]  strb_s;
  logic [NCH-1:0] sel;
  logic [NCH-1:0] chg;
  logic [DW-1:0]  code [NCH];
  op_e            op;
  logic           upd_q, upd_nxt;

  dac_strobe_sync #(
    .W       (SW),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (STRB_RST)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({clr_n_i, load_i, wr_n_i}),
    .q     (strb_s)
  );

  assign op = decode_op(strb_s[2], strb_s[0], strb_s[1]);

  dac_addr_decode u_dec (
    .addr (addr_i),
    .sel  (sel)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dac_chan_regs #(.DW(DW)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .op      (op),
      .sel     (sel[ch]),
      .mid_sel (mid_sel_i),
      .data    (data_i),
      .code    (code[ch]),
      .chg     (chg[ch])
    );
  end

  always_comb begin
    upd_nxt = |chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= upd_nxt;
  end

  assign code_a_o = code[0];
  assign code_b_o = code[1];
  assign upd_o    = upd_q;

endmodule

// File: rtl/dual_dac_regs_chk.sv
module dual_dac_regs_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] data_i,
  input logic [1:0]    addr_i,
  input logic          wr_n_i,
  input logic          load_i,
  input logic          clr_n_i,
  input logic          mid_sel_i,
  input logic [DW-1:0] code_a_o,
  input logic [DW-1:0] code_b_o,
  input logic          upd_o
);

  logic [2:0] since_q;
  logic       armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 3'd7) since_q <= since_q + 3'd1;
  end

  assign armed = (since_q >= 3'd4);

  // R6 and R7: clear seen three edges back forces both codes to the preset
  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(clr_n_i, 3)) |->
      (code_a_o == {$past(mid_sel_i, 1), {(DW-1){1'b0}}}) &&
      (code_b_o == {$past(mid_sel_i, 1), {(DW-1){1'b0}}}));

  // R5: hold action leaves both codes untouched
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(clr_n_i, 3) && $past(wr_n_i, 3) && !$past(load_i, 3)) |->
      ($stable(code_a_o) && $stable(code_b_o)));

  // R1: the "neither" address never moves a code
  a_r1_none: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(clr_n_i, 3) && ($past(addr_i, 1) == 2'b01)) |->
      ($stable(code_a_o) && $stable(code_b_o)));

  // R4: pass-through on channel A copies the bus
  a_r4_thru: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(clr_n_i, 3) && !$past(wr_n_i, 3) && $past(load_i, 3) &&
     (($past(addr_i, 1) == 2'b00) || ($past(addr_i, 1) == 2'b10))) |->
      (code_a_o == $past(data_i, 1)));

  // R11: update pulse marks exactly the cycles with a changed code
  a_r11_upd: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (upd_o == ((code_a_o != $past(code_a_o)) || (code_b_o != $past(code_b_o)))));

endmodule

bind dual_dac_regs dual_dac_regs_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .data_i    (data_i),
  .addr_i    (addr_i),
  .wr_n_i    (wr_n_i),
  .load_i    (load_i),
  .clr_n_i   (clr_n_i),
  .mid_sel_i (mid_sel_i),
  .code_a_o  (code_a_o),
  .code_b_o  (code_b_o),
  .upd_o     (upd_o)
);

// File: tb/dual_dac_regs_test.sv
module dual_dac_regs_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] data_i;
  logic [1:0]  addr_i;
  logic        wr_n_i, load_i, clr_n_i, mid_sel_i;
  logic [15:0] code_a_o, code_b_o;
  logic        upd_o;

  int n_checks = 0;
  int n_fails  = 0;
  int pulses   = 0;

  logic [15:0] stg_m [2];
  logic [15:0] out_m [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_regs uut (
    .clk(clk), .rst_n(rst_n), .data_i(data_i), .addr_i(addr_i),
    .wr_n_i(wr_n_i), .load_i(load_i), .clr_n_i(clr_n_i), .mid_sel_i(mid_sel_i),
    .code_a_o(code_a_o), .code_b_o(code_b_o), .upd_o(upd_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (upd_o) pulses++;
    end
  endtask

  task automatic check_codes(input string req);
    check(req, {16'h0, code_a_o}, {16'h0, out_m[0]});
    check(req, {16'h0, code_b_o}, {16'h0, out_m[1]});
  endtask

  function automatic logic sel_of(input logic [1:0] a, input int ch);
    if (ch == 0) return (a == 2'b00) || (a == 2'b10);
    else         return (a == 2'b11) || (a == 2'b10);
  endfunction

  // op: 0 capture, 1 transfer, 2 pass-through, 3 hold
  task automatic do_op(input int op, input logic [1:0] a, input logic [15:0] d);
    logic [15:0] old0, old1;
    string tag;
    old0 = out_m[0];
    old1 = out_m[1];
    data_i = d;
    addr_i = a;
    case (op)
      0: begin wr_n_i = 1'b0; load_i = 1'b0; tag = "R1 R2 capture"; end
      1: begin wr_n_i = 1'b1; load_i = 1'b1; tag = "R1 R3 transfer"; end
      2: begin wr_n_i = 1'b0; load_i = 1'b1; tag = "R1 R4 thru"; end
      default: begin wr_n_i = 1'b1; load_i = 1'b0; tag = "R5 hold"; end
    endcase
    pulses = 0;
    tick(4);
    for (int ch = 0; ch < 2; ch++) begin
      if (sel_of(a, ch)) begin
        case (op)
          0: stg_m[ch] = d;
          1: out_m[ch] = stg_m[ch];
          2: begin stg_m[ch] = d; out_m[ch] = d; end
          default: ;
        endcase
      end
    end
    check_codes(tag);
    check("R11 pulse count", pulses, ((out_m[0] != old0) || (out_m[1] != old1)) ? 1 : 0);
    wr_n_i = 1'b1;
    load_i = 1'b0;
    pulses = 0;
    tick(4);
    check_codes("R5 idle after op");
    check("R11 no pulse in idle", pulses, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL R10 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    rst_n = 1'b0; clr_n_i = 1'b1; wr_n_i = 1'b1; load_i = 1'b0;
    mid_sel_i = 1'b1; data_i = 16'h1234; addr_i = 2'b10;
    tick(3);
    // R8: reset state
    check("R8 reset code A", {16'h0, code_a_o}, 32'h0);
    check("R8 reset code B", {16'h0, code_b_o}, 32'h0);
    check("R8 reset pulse", {31'h0, upd_o}, 32'h0);
    rst_n = 1'b1;
    tick(3);
    // R8 and R7: power-on preset, midscale
    check("R8 R7 power-on A", {16'h0, code_a_o}, 32'h8000);
    check("R8 R7 power-on B", {16'h0, code_b_o}, 32'h8000);
    stg_m[0] = 16'h8000; stg_m[1] = 16'h8000;
    out_m[0] = 16'h8000; out_m[1] = 16'h8000;
    tick(2);

    // Sweep: every action at every address, changing data
    for (int k = 0; k < 6; k++) begin
      for (int a = 0; a < 4; a++) begin
        for (int op = 0; op < 4; op++) begin
          d = 16'(((k * 16 + a * 4 + op + 1) * 16'h3C5B) ^ 16'hA5A5);
          if (k == 0 && op == 0) d = (a[0]) ? 16'hFFFF : 16'h0000;
          do_op(op, 2'(a), d);
        end
        // expose staging contents through a transfer to both channels
        do_op(1, 2'b10, 16'h0);
      end
    end

    // R9: tied strobe pulse to both channels
    data_i = 16'hC3A1; addr_i = 2'b10;
    wr_n_i = 1'b0; load_i = 1'b0; pulses = 0;
    tick(4);
    check_codes("R9 pulse low stages only");
    wr_n_i = 1'b1; load_i = 1'b1;
    tick(4);
    stg_m[0] = 16'hC3A1; stg_m[1] = 16'hC3A1;
    out_m[0] = 16'hC3A1; out_m[1] = 16'hC3A1;
    check_codes("R9 pulse high transfers");
    check("R9 R11 one pulse", pulses, 1);
    wr_n_i = 1'b1; load_i = 1'b0;
    tick(4);

    // R10: latency through synchroniser and register
    data_i = 16'h0F0F; addr_i = 2'b00;
    wr_n_i = 1'b0; load_i = 1'b1;
    tick(2);
    check("R10 not yet after two edges", {16'h0, code_a_o}, {16'h0, out_m[0]});
    tick(1);
    check("R10 visible after three edges", {16'h0, code_a_o}, 32'h0F0F);
    stg_m[0] = 16'h0F0F; out_m[0] = 16'h0F0F;
    tick(1);
    wr_n_i = 1'b1; load_i = 1'b0;
    tick(4);

    // R6 R7: clear wins over pass-through, zero-scale preset
    mid_sel_i = 1'b0; data_i = 16'h7777; addr_i = 2'b10;
    clr_n_i = 1'b0; wr_n_i = 1'b0; load_i = 1'b1;
    tick(4);
    out_m[0] = 16'h0000; out_m[1] = 16'h0000;
    stg_m[0] = 16'h0000; stg_m[1] = 16'h0000;
    check_codes("R6 R7 clear zero-scale");
    wr_n_i = 1'b1; load_i = 1'b0;
    tick(4);
    clr_n_i = 1'b1;
    tick(4);
    check_codes("R6 after clear release");
    do_op(1, 2'b10, 16'h5A5A); // staging must hold the preset too

    // R6 R7: midscale preset with capture requested
    do_op(2, 2'b10, 16'h1111);
    mid_sel_i = 1'b1;
    clr_n_i = 1'b0; wr_n_i = 1'b0; load_i = 1'b0; addr_i = 2'b01;
    tick(4);
    out_m[0] = 16'h8000; out_m[1] = 16'h8000;
    stg_m[0] = 16'h8000; stg_m[1] = 16'h8000;
    check_codes("R6 R7 clear midscale");
    wr_n_i = 1'b1; load_i = 1'b0;
    tick(4);
    clr_n_i = 1'b1;
    tick(4);
    do_op(1, 2'b10, 16'h2222);
    check_codes("R6 staging preset midscale");

    // R8: power-on with zero-scale preset
    do_op(2, 2'b10, 16'h4321);
    mid_sel_i = 1'b0;
    rst_n = 1'b0;
    tick(2);
    check("R8 reset again A", {16'h0, code_a_o}, 32'h0);
    rst_n = 1'b1;
    tick(3);
    check("R8 R7 power-on zero A", {16'h0, code_a_o}, 32'h0);
    check("R8 R7 power-on zero B", {16'h0, code_b_o}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

endmodule